// File: doc/BRIEF.md
# Sequential Signed Divider with Sign Correction and Cycle Accounting

The block divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor. On a start pulse it captures both operands, takes their magnitudes and checks whether the quotient cannot possibly fit. If the quotient might fit, it runs one restoring shift/compare/subtract step per clock to build a 16-bit magnitude quotient. A final correction stage then gives the quotient and remainder their signs according to the sign combination of the operands, and catches any quotient that still falls outside the signed 16-bit range.

Each completion produces a one-cycle `done` pulse. The pulse comes with a packed word that holds the remainder in the upper half and the quotient in the lower half, a write-enable, and negative, zero and overflow flags. It also reports a modelled execution-time figure. That figure depends on the operand signs, on each quotient bit and on the correction case, and it is multiplied by a clock-divider input. A zero divisor is reported on an error output and no division is run.

Top module: `sdiv_seq_top`

## Requirements
- R1: A start pulse is accepted only while the unit is idle. A start raised during a running division is ignored: that division completes with its own operands and no extra completion follows.
- R2: A zero divisor completes one cycle after start. It gives `div_zero`=1, `wr_en`=0 and N=Z=V=0, and reports `cycles` = 8 × `clk_div`.
- R3: Early overflow occurs when the divisor is nonzero and |dividend| ≥ |divisor| × 65536. It completes one cycle after start with V=1, N=1, Z=0 and `wr_en`=0.
- R4: Any operation that is neither a zero divisor nor an early overflow completes exactly 17 clock edges after the edge that accepted start, counting that edge.
- R5: A successful division pulses `wr_en` together with `done`. `result[15:0]` holds the signed quotient truncated toward zero, and `result[31:16]` holds the remainder, whose sign follows the dividend.
- R6: Late overflow occurs when the signed quotient lies outside −32768..32767. It sets V=1, N=1 and Z=0, and `wr_en` stays 0.
- R7: On a successful division, N equals quotient bit 15, Z is 1 exactly when the quotient is zero, and V is 0.
- R8: The cycle total is built as follows. Start at 8 and add 2 for a negative dividend. Then add either 4 for an early overflow, or the following sum: 6 for each 1 and 8 for each 0 among quotient-magnitude bits 15 down to 1, plus 4 for bit 0, plus a correction cost. The correction cost is 14 when both operands are non-negative, 16 when the divisor is negative and 18 when only the dividend is negative. `cycles` reports this total times `clk_div` on every completion path.
- R9: `done` and `wr_en` are high for one cycle per completion. `result` keeps its value until the next successful division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division with the operands present at this edge |
| dividend | input | 32 | Two's-complement dividend |
| divisor | input | 16 | Two's-complement divisor |
| clk_div | input | 4 | Multiplier applied to the reported cycle total |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Result is valid and should be written (with done) |
| div_zero | output | 1 | Last completion was a zero divisor |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| result | output | 32 | Remainder (upper half) and quotient (lower half) |
| cycles | output | 12 | Cycle total times clk_div |

## Verification
The assertions take no limit on operand values for granted. They do assume that `start` is sampled only at clock edges, and that a start seen while idle always leads, on the next edge, either to a completion or to the running state. The stimulus raises start for one cycle per operation from a falling edge. It creates operands by picking a target quotient and a remainder smaller than the divisor, so that successful, late-overflow and early-overflow outcomes all occur often. Directed operands add the zero divisor, the most negative dividend and quotients at the edges of the signed 16-bit range.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // {divisor_negative, dividend_negative}
    typedef enum logic [1:0] {
        SC_BOTH_POS = 2'b00,
        SC_DVD_NEG  = 2'b01,
        SC_DVR_NEG  = 2'b10,
        SC_BOTH_NEG = 2'b11
    } sign_case_e;

    localparam int COST_BASE      = 8;
    localparam int COST_NEG_DVD   = 2;
    localparam int COST_EARLY_OVF = 4;
    localparam int COST_SUB       = 6;
    localparam int COST_NOSUB     = 8;
    localparam int COST_LAST      = 4;
    localparam int COST_FIX_PP    = 14;
    localparam int COST_FIX_DVR   = 16;
    localparam int COST_FIX_DVD   = 18;

    function automatic sign_case_e classify(input logic dvr_neg, input logic dvd_neg);
        return sign_case_e'({dvr_neg, dvd_neg});
    endfunction

    function automatic int fix_cost(input sign_case_e sc);
        case (sc)
            SC_BOTH_POS: return COST_FIX_PP;
            SC_DVD_NEG:  return COST_FIX_DVD;
            default:     return COST_FIX_DVR;
        endcase
    endfunction

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep import sdiv_pkg::*; #(
    parameter int DVR_W = 16,
    parameter int CYC_W = 8,
    localparam int DVD_W = 2 * DVR_W
) (
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVR_W-1:0] divisor,
    output logic [DVD_W-1:0] dvd_mag,
    output logic [DVD_W-1:0] dsh_mag,
    output logic             dvd_neg,
    output logic             dvr_neg,
    output logic             dvr_zero,
    output logic             early_ovf,
    output logic [CYC_W-1:0] base_cost
);
    logic [DVD_W-1:0] dsh_raw;

    always_comb begin
        dvd_neg   = dividend[DVD_W-1];
        dvr_neg   = divisor[DVR_W-1];
        dvd_mag   = dvd_neg ? (~dividend + 1'b1) : dividend;
        dsh_raw   = {divisor, {DVR_W{1'b0}}};
        dsh_mag   = dvr_neg ? (~dsh_raw + 1'b1) : dsh_raw;
        dvr_zero  = (divisor == '0);
        early_ovf = (dsh_mag <= dvd_mag);
        base_cost = CYC_W'(COST_BASE) + (dvd_neg ? CYC_W'(COST_NEG_DVD) : CYC_W'(0));
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int DVR_W = 16,
    localparam int DVD_W = 2 * DVR_W
) (
    input  logic [DVD_W-1:0] rem_in,
    input  logic [DVD_W-1:0] dsh,
    input  logic [DVR_W-1:0] q_in,
    output logic [DVD_W-1:0] rem_out,
    output logic [DVR_W-1:0] q_out,
    output logic             take
);
    logic [DVD_W-1:0] shifted;

    always_comb begin
        shifted = {rem_in[DVD_W-2:0], 1'b0};
        take    = (shifted >= dsh);
        rem_out = take ? (shifted - dsh) : shifted;
        q_out   = {q_in[DVR_W-2:0], take};
    end
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup import sdiv_pkg::*; #(
    parameter int DVR_W = 16,
    parameter int CYC_W = 8,
    localparam int DVD_W = 2 * DVR_W
) (
    input  logic [DVD_W-1:0] rem_mag,
    input  logic [DVR_W-1:0] q_mag,
    input  logic             dvd_neg,
    input  logic             dvr_neg,
    output logic [DVD_W-1:0] packed_res,
    output logic             ovf,
    output logic             neg,
    output logic             zero,
    output logic [CYC_W-1:0] cost
);
    sign_case_e       sc;
    logic [DVR_W-1:0] q_inv;
    logic [DVR_W-1:0] q_fin;
    logic [DVD_W-1:0] rem_inv;
    logic [DVD_W-1:0] rem_fin;
    logic             inv_bad;

    always_comb begin
        sc      = classify(dvr_neg, dvd_neg);
        q_inv   = ~q_mag + 1'b1;
        rem_inv = ~rem_mag + 1'b1;
        inv_bad = (q_inv != '0) && !q_inv[DVR_W-1];
        q_fin   = q_mag;
        rem_fin = rem_mag;
        ovf     = 1'b0;
        case (sc)
            SC_BOTH_POS: begin
                ovf = q_mag[DVR_W-1];
            end
            SC_DVR_NEG: begin
                q_fin = q_inv;
                ovf   = inv_bad;
            end
            SC_BOTH_NEG: begin
                ovf     = q_mag[DVR_W-1];
                rem_fin = rem_inv;
            end
            default: begin
                q_fin   = q_inv;
                ovf     = inv_bad;
                rem_fin = rem_inv;
            end
        endcase
        cost       = CYC_W'(fix_cost(sc));
        packed_res = rem_fin | {{DVR_W{1'b0}}, q_fin};
        neg        = ovf | q_fin[DVR_W-1];
        zero       = !ovf && (q_fin == '0);
    end
endmodule

// File: rtl/sdiv_seq_top.sv
module sdiv_seq_top import sdiv_pkg::*; #(
    parameter int DVR_W = 16,
    parameter int DIV_W = 4,
    localparam int DVD_W = 2 * DVR_W,
    localparam int CYC_W = $clog2(32 + 8 * DVR_W + 1),
    localparam int OUT_W = CYC_W + DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVR_W-1:0] divisor,
    input  logic [DIV_W-1:0] clk_div,
    output logic             done,
    output logic             wr_en,
    output logic             div_zero,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic [DVD_W-1:0] result,
    output logic [OUT_W-1:0] cycles
);
    localparam int STEP_W = $clog2(DVR_W);

    div_state_e        state_q;
    logic [DVD_W-1:0]  rem_q;
    logic [DVD_W-1:0]  dsh_q;
    logic [DVR_W-1:0]  q_q;
    logic [STEP_W-1:0] step_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [DIV_W-1:0]  div_q;
    logic              dvd_neg_q;
    logic              dvr_neg_q;
    logic              running;

    logic [DVD_W-1:0]  p_dvd_mag, p_dsh_mag;
    logic              p_dvd_neg, p_dvr_neg, p_zero, p_early;
    logic [CYC_W-1:0]  p_base;

    logic [DVD_W-1:0]  s_rem;
    logic [DVR_W-1:0]  s_q;
    logic              s_take;

    logic [DVD_W-1:0]  f_res;
    logic              f_ovf, f_n, f_z;
    logic [CYC_W-1:0]  f_cost;

    logic              last_step;
    logic [CYC_W-1:0]  step_cost;
    logic [CYC_W-1:0]  cyc_nx;
    logic [CYC_W-1:0]  cyc_total;
    logic [OUT_W-1:0]  scaled_run, scaled_zero, scaled_early;

    sdiv_prep #(.DVR_W(DVR_W), .CYC_W(CYC_W)) prep_i (
        .dividend  (dividend),
        .divisor   (divisor),
        .dvd_mag   (p_dvd_mag),
        .dsh_mag   (p_dsh_mag),
        .dvd_neg   (p_dvd_neg),
        .dvr_neg   (p_dvr_neg),
        .dvr_zero  (p_zero),
        .early_ovf (p_early),
        .base_cost (p_base)
    );

    sdiv_step #(.DVR_W(DVR_W)) step_i (
        .rem_in  (rem_q),
        .dsh     (dsh_q),
        .q_in    (q_q),
        .rem_out (s_rem),
        .q_out   (s_q),
        .take    (s_take)
    );

    sdiv_fixup #(.DVR_W(DVR_W), .CYC_W(CYC_W)) fix_i (
        .rem_mag    (s_rem),
        .q_mag      (s_q),
        .dvd_neg    (dvd_neg_q),
        .dvr_neg    (dvr_neg_q),
        .packed_res (f_res),
        .ovf        (f_ovf),
        .neg        (f_n),
        .zero       (f_z),
        .cost       (f_cost)
    );

    always_comb begin
        running      = (state_q == ST_RUN);
        last_step    = (step_q == STEP_W'(DVR_W - 1));
        step_cost    = last_step ? CYC_W'(COST_LAST)
                     : (s_take ? CYC_W'(COST_SUB) : CYC_W'(COST_NOSUB));
        cyc_nx       = cyc_q + step_cost;
        cyc_total    = cyc_nx + f_cost;
        scaled_run   = OUT_W'(cyc_total) * OUT_W'(div_q);
        scaled_zero  = OUT_W'(COST_BASE) * OUT_W'(clk_div);
        scaled_early = OUT_W'(p_base + CYC_W'(COST_EARLY_OVF)) * OUT_W'(clk_div);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            dsh_q     <= '0;
            q_q       <= '0;
            step_q    <= '0;
            cyc_q     <= '0;
            div_q     <= '0;
            dvd_neg_q <= 1'b0;
            dvr_neg_q <= 1'b0;
            done      <= 1'b0;
            wr_en     <= 1'b0;
            div_zero  <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            result    <= '0;
            cycles    <= '0;
        end else begin
            done  <= 1'b0;
            wr_en <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        rem_q     <= p_dvd_mag;
                        dsh_q     <= p_dsh_mag;
                        q_q       <= '0;
                        step_q    <= '0;
                        cyc_q     <= p_base;
                        div_q     <= clk_div;
                        dvd_neg_q <= p_dvd_neg;
                        dvr_neg_q <= p_dvr_neg;
                        if (p_zero) begin
                            done     <= 1'b1;
                            div_zero <= 1'b1;
                            flag_n   <= 1'b0;
                            flag_z   <= 1'b0;
                            flag_v   <= 1'b0;
                            cycles   <= scaled_zero;
                        end else if (p_early) begin
                            done     <= 1'b1;
                            div_zero <= 1'b0;
                            flag_n   <= 1'b1;
                            flag_z   <= 1'b0;
                            flag_v   <= 1'b1;
                            cycles   <= scaled_early;
                        end else begin
                            state_q  <= ST_RUN;
                        end
                    end
                end
                default: begin
                    rem_q  <= s_rem;
                    q_q    <= s_q;
                    cyc_q  <= cyc_nx;
                    step_q <= step_q + 1'b1;
                    if (last_step) begin
                        state_q  <= ST_IDLE;
                        done     <= 1'b1;
                        div_zero <= 1'b0;
                        wr_en    <= !f_ovf;
                        flag_n   <= f_n;
                        flag_z   <= f_z;
                        flag_v   <= f_ovf;
                        cycles   <= scaled_run;
                        if (!f_ovf) begin
                            result <= f_res;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sdiv_seq_chk.sv
module sdiv_seq_chk #(
    parameter int DVR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             running,
    input logic             done,
    input logic             wr_en,
    input logic             div_zero,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v,
    input logic [DVR_W-1:0] q_lo
);
    AST_ACCEPT_PROGRESS: assert property (@(posedge clk) disable iff (rst)
        (start && !running) |=> (done || running)); // R4

    AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done); // R9

    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done && flag_v) |-> (!wr_en && flag_n && !flag_z)); // R6

    AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!flag_v && (flag_n == q_lo[DVR_W-1]) && (flag_z == (q_lo == '0)))); // R7

    AST_ZERO_DIV: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (!wr_en && !flag_v && !flag_n && !flag_z)); // R2

    AST_RUN_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (running && start) |=> !(done && div_zero)); // R1
endmodule

bind sdiv_seq_top sdiv_seq_chk #(.DVR_W(DVR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .running  (running),
    .done     (done),
    .wr_en    (wr_en),
    .div_zero (div_zero),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .q_lo     (result[DVR_W-1:0])
);

// File: tb/sdiv_seq_top_tb.sv
`timescale 1ns/1ps
module sdiv_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [3:0]  clk_div = '0;
    logic        done, wr_en, div_zero, flag_n, flag_z, flag_v;
    logic [31:0] result;
    logic [11:0] cycles;

    int total = 0;
    int fails = 0;
    int edge_cnt = 0;

    always #2.5 clk = ~clk;

    sdiv_seq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .clk_div(clk_div), .done(done), .wr_en(wr_en), .div_zero(div_zero),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .result(result), .cycles(cycles)
    );

    typedef struct {
        int          lat;
        bit          err;
        bit          wr;
        bit          n;
        bit          z;
        bit          v;
        logic [31:0] res;
        longint      cyc;
    } exp_t;

    always @(posedge clk) begin
        edge_cnt++;
        if (edge_cnt > 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: run hung, act=%0d exp<150000 edges", edge_cnt);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] a, input logic [15:0] b, input logic [3:0] k);
        exp_t   e;
        longint sa, sb, ua, ub, qm, q, r, c;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = (sa < 0) ? -sa : sa;
        ub = (sb < 0) ? -sb : sb;
        e = '{lat: 1, err: 0, wr: 0, n: 0, z: 0, v: 0, res: '0, cyc: 0};
        c = 8 + ((sa < 0) ? 2 : 0);
        if (sb == 0) begin
            e.err = 1;
            e.cyc = 8 * longint'(k);
            return e;
        end
        if (ua >= ub * 65536) begin
            e.v = 1; e.n = 1; e.z = 0;
            e.cyc = (c + 4) * longint'(k);
            return e;
        end
        e.lat = 17;
        qm = ua / ub;
        for (int i = 15; i >= 1; i--) c += qm[i] ? 6 : 8;
        c += 4;
        c += (sb < 0) ? 16 : ((sa < 0) ? 18 : 14);
        e.cyc = c * longint'(k);
        q = sa / sb;
        r = sa % sb;
        if (q > 32767 || q < -32768) begin
            e.v = 1; e.n = 1; e.z = 0;
        end else begin
            e.wr  = 1;
            e.res = {r[15:0], q[15:0]};
            e.n   = q < 0;
            e.z   = q == 0;
        end
        return e;
    endfunction

    logic [31:0] last_res = '0;

    task automatic run_op(input logic [31:0] a, input logic [15:0] b, input logic [3:0] k, input bit poke);
        exp_t e;
        int   n;
        bit   got;
        e = model(a, b, k);
        @(negedge clk);
        dividend = a; divisor = b; clk_div = k; start = 1'b1;
        n = 0; got = 0;
        while (!got && n < 40) begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (done) got = 1;
            else if (poke && n == 5) begin
                start = 1'b1; dividend = 32'h0000_0000; divisor = 16'h0000; clk_div = 4'hF;
            end
        end
        chk(e.err ? "R2 latency" : (e.lat == 1 ? "R3 latency" : "R4 latency"), n, e.lat);
        chk("R2 div_zero", div_zero, e.err);
        chk(e.v ? "R6 wr_en" : "R5 wr_en", wr_en, e.wr);
        chk(e.v ? "R3/R6 flag_v" : "R7 flag_v", flag_v, e.v);
        chk(e.v ? "R3/R6 flag_n" : "R7 flag_n", flag_n, e.n);
        chk(e.v ? "R3/R6 flag_z" : "R7 flag_z", flag_z, e.z);
        chk("R8 cycles", cycles, e.cyc);
        if (e.wr) begin
            chk("R5 result", result, e.res);
            last_res = e.res;
        end
        @(negedge clk);
        chk("R9 done pulse", done, 0);
        chk("R9 wr_en pulse", wr_en, 0);
        chk("R9 result held", result, last_res);
        if (poke) begin
            got = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (done) got = 1;
            end
            chk("R1 start ignored while running", got, 0);
        end
    endtask

    initial begin
        int unsigned seed;
        longint qq, rr, bb, aa;
        logic [15:0] rb;
        seed = 32'h1d5a_0c37;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        chk("reset done", done, 0);
        chk("reset wr_en", wr_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("reset cycles", cycles, 0);
        chk("reset div_zero", div_zero, 0);

        // directed corners
        run_op(32'd100, 16'd7, 4'd1, 0);               // R5 both positive
        run_op(-32'sd100, 16'd7, 4'd2, 0);             // R5 negative dividend
        run_op(32'd100, -16'sd7, 4'd3, 0);             // R5 negative divisor
        run_op(-32'sd100, -16'sd7, 4'd1, 0);           // R5 both negative
        run_op(32'd0, 16'd5, 4'd1, 0);                 // R7 zero quotient
        run_op(32'd12345, 16'd0, 4'd3, 0);             // R2 zero divisor
        run_op(32'h8000_0000, 16'hFFFF, 4'd1, 0);      // R3 most negative / -1
        run_op(32'h0001_0000, 16'd1, 4'd1, 0);         // R3 boundary equal
        run_op(32'h0000_FFFF, 16'd1, 4'd1, 0);         // R6 late overflow, pos/pos
        run_op(32'h0000_8000, 16'd1, 4'd2, 0);         // R6 quotient 32768
        run_op(-32'sd32768, 16'd1, 4'd1, 0);           // R5 quotient -32768
        run_op(32'h0000_8000, 16'hFFFF, 4'd1, 0);      // R5 32768 / -1 fits
        run_op(-32'sd32769, 16'd1, 4'd1, 0);           // R6 late overflow neg dvd
        run_op(32'h0000_8001, 16'hFFFF, 4'd1, 0);      // R6 late overflow neg dvr
        run_op(-32'sd32768, 16'hFFFF, 4'd1, 0);        // R6 both negative, q=32768
        run_op(32'd1000, 16'd3, 4'd0, 0);              // R8 zero divider scale
        run_op(32'd70000, 16'd9, 4'd5, 1);             // R1 start while running

        // constrained random
        for (int i = 0; i < 400; i++) begin
            rb = 16'($urandom());
            if (i % 17 == 0) rb = 16'h0000;
            bb = longint'($signed(rb));
            case ($urandom() % 4)
                0: aa = longint'($signed(32'($urandom())));
                default: begin
                    qq = longint'($urandom() % 90000) - 45000;
                    rr = (bb == 0) ? 0 : longint'($urandom() % 65536) % ((bb < 0) ? -bb : bb);
                    if (qq < 0) rr = -rr;
                    aa = qq * bb + rr;
                end
            endcase
            run_op(32'(aa), rb, 4'($urandom()), 0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule